// File: doc/BRIEF.md
# Bank-Switched Dual-Port Memory

This block is a synchronous shared word memory split into equal banks, each of which belongs to exactly one of two ports (left and right) at any moment. A select input per bank hands that bank to one side or the other at run time. Since a bank has only one owner, the two ports can never collide, and no arbitration is needed. Each port has its own chip enables, mailbox-select guard, write and output enables, upper and lower byte enables, bank address, word address, write data and read data.

A port reads and writes only the banks it currently owns. An access to a bank it does not own does nothing, returns zero and raises a one-cycle error pulse. A change of ownership takes effect at the next clock edge. In the cycle a bank's select input differs from the registered owner, its current owner cannot access it, because traffic to a bank that is being reassigned must pause. The full-size build uses 4 banks of 16K x 16 bits (`ADDR_W` = 14). The default `ADDR_W` of 8 keeps elaboration small.

Top module: `bsw_dpram`

## Requirements
- R1: A port addresses word `addr_i` (ADDR_W bits) inside bank `bank_i` (2 bits for 4 banks). Every bank and word holds its own 16-bit value, including address 0 and the top address.
- R2: Bank b belongs to the left port when its registered select bit is 1 and to the right port when it is 0. The register loads `bank_sel_i` on every clock and resets to 0, so after reset the right port owns every bank. One port may own any number of banks, from none to all.
- R3: A port is selected only when `ce_n_i`=0 and `ce_i`=1. Any other combination writes nothing, raises no error, and gives zero read data.
- R4: A write (`we_n_i`=0 on a selected, granted port) stores bits 15:8 when `ub_n_i`=0 and bits 7:0 when `lb_n_i`=0. A byte whose enable is 1 keeps its old value.
- R5: A read needs `we_n_i`=1 and `oe_n_i`=0. It returns the stored bytes whose enables are 0 and zero in the other bytes. With `oe_n_i`=1 the read data is zero.
- R6: Read data and the error flag are registered. They appear in the cycle after the request and are zero in every other cycle and after reset.
- R7: A selected memory access to a bank that the registered select does not give to the port writes nothing, returns zero, and sets `err_o` for exactly the following cycle.
- R8: Asserting `mbx_n_i`=0 while the port is selected is illegal. The memory access is ignored and `err_o` is set in the next cycle.
- R9: When `bank_sel_i[b]` differs from its registered value, an access by the registered owner to bank b is dropped: no write, zero data, no error.
- R10: Both ports operate in the same cycle on different banks without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_sel_i | input | NBANK | Per-bank owner select, 1 = left, 0 = right |
| l_ce_n_i | input | 1 | Left chip enable, active low |
| l_ce_i | input | 1 | Left chip enable, active high |
| l_mbx_n_i | input | 1 | Left mailbox select, active low (must stay high for memory access) |
| l_we_n_i | input | 1 | Left write enable, active low |
| l_oe_n_i | input | 1 | Left output enable, active low |
| l_ub_n_i | input | 1 | Left upper byte enable, active low |
| l_lb_n_i | input | 1 | Left lower byte enable, active low |
| l_bank_i | input | BA_W | Left bank address |
| l_addr_i | input | ADDR_W | Left word address |
| l_wdata_i | input | 16 | Left write data |
| l_rdata_o | output | 16 | Left read data, registered |
| l_err_o | output | 1 | Left illegal-access pulse |
| r_ce_n_i | input | 1 | Right chip enable, active low |
| r_ce_i | input | 1 | Right chip enable, active high |
| r_mbx_n_i | input | 1 | Right mailbox select, active low |
| r_we_n_i | input | 1 | Right write enable, active low |
| r_oe_n_i | input | 1 | Right output enable, active low |
| r_ub_n_i | input | 1 | Right upper byte enable, active low |
| r_lb_n_i | input | 1 | Right lower byte enable, active low |
| r_bank_i | input | BA_W | Right bank address |
| r_addr_i | input | ADDR_W | Right word address |
| r_wdata_i | input | 16 | Right write data |
| r_rdata_o | output | 16 | Right read data, registered |
| r_err_o | output | 1 | Right illegal-access pulse |

## Verification
An ownership change and an access to the bank being moved can fall in the same cycle. The bench changes `bank_sel_i` in the very cycle that the outgoing owner writes the bank and the incoming owner writes it too. It then reads the bank after the change settles and expects the outgoing write to be dropped silently, the incoming write to be flagged, and the stored word to be unchanged. Simultaneous traffic from both ports to separate banks is also driven on every fill and read cycle. A behavioural model compares both read buses and both error flags on every clock.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic       wr;
    logic       rd;
    logic [1:0] be;  // active high, [1] = upper byte
  } acc_t;

  function automatic logic [DATA_W-1:0] byte_mask(input logic [1:0] be);
    return {{BYTE_W{be[1]}}, {BYTE_W{be[0]}}};
  endfunction
endpackage

// File: rtl/bsw_bank.sv
module bsw_bank
  import bsw_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 2 ** ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [1:0]        be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar k = 0; k < 2; k++) begin : g_byte
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[k]) mem_q[addr_i][k*BYTE_W +: BYTE_W] <= wdata_i[k*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/bsw_port.sv
module bsw_port
  import bsw_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter bit IS_LEFT = 1'b1,
  localparam int BA_W   = $clog2(NBANK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_n_i,
  input  logic             ce_i,
  input  logic             mbx_n_i,
  input  logic             we_n_i,
  input  logic             oe_n_i,
  input  logic             ub_n_i,
  input  logic             lb_n_i,
  input  logic [BA_W-1:0]  bank_i,
  input  logic [NBANK-1:0] own_i,   // registered owners, 1 = left
  input  logic [NBANK-1:0] sel_i,   // incoming owners
  output acc_t             acc_o,
  output logic             err_o,
  output logic             fire_o,
  output logic [BA_W-1:0]  bank_q_o,
  output logic [1:0]       be_q_o
);
  logic chip, mem_sel, clash, mine, moving, gnt;

  always_comb begin
    chip    = !ce_n_i && ce_i;
    mem_sel = chip && mbx_n_i;
    clash   = chip && !mbx_n_i;
    mine    = (own_i[bank_i] == IS_LEFT);
    moving  = (sel_i[bank_i] != own_i[bank_i]);
    gnt     = mem_sel && mine && !moving;
    acc_o.wr = gnt && !we_n_i;
    acc_o.rd = gnt && we_n_i && !oe_n_i;
    acc_o.be = {!ub_n_i, !lb_n_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o    <= 1'b0;
      fire_o   <= 1'b0;
      bank_q_o <= '0;
      be_q_o   <= '0;
    end else begin
      err_o    <= clash || (mem_sel && !mine);
      fire_o   <= acc_o.rd;
      bank_q_o <= bank_i;
      be_q_o   <= acc_o.be;
    end
  end

  assert_sel_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ce_i && !ce_n_i) |=> (!err_o && !fire_o));
  assert_mbx_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !ce_n_i && !mbx_n_i) |=> (err_o && !fire_o));
  assert_oe_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |=> !fire_o);
endmodule

// File: rtl/bsw_dpram.sv
module bsw_dpram
  import bsw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBANK  = 4,
  localparam int BA_W  = $clog2(NBANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NBANK-1:0]  bank_sel_i,
  input  logic              l_ce_n_i,
  input  logic              l_ce_i,
  input  logic              l_mbx_n_i,
  input  logic              l_we_n_i,
  input  logic              l_oe_n_i,
  input  logic              l_ub_n_i,
  input  logic              l_lb_n_i,
  input  logic [BA_W-1:0]   l_bank_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_err_o,
  input  logic              r_ce_n_i,
  input  logic              r_ce_i,
  input  logic              r_mbx_n_i,
  input  logic              r_we_n_i,
  input  logic              r_oe_n_i,
  input  logic              r_ub_n_i,
  input  logic              r_lb_n_i,
  input  logic [BA_W-1:0]   r_bank_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_err_o
);
  logic [NBANK-1:0]  own_q;
  acc_t              l_acc, r_acc;
  logic              l_fire, r_fire;
  logic [BA_W-1:0]   l_bank_q, r_bank_q;
  logic [1:0]        l_be_q, r_be_q;
  logic [NBANK-1:0]  l_hit, r_hit;
  logic [DATA_W-1:0] bank_rd [NBANK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) own_q <= '0;
    else         own_q <= bank_sel_i;
  end

  bsw_port #(.NBANK(NBANK), .IS_LEFT(1'b1)) u_port_l (
    .clk_i, .rst_ni,
    .ce_n_i(l_ce_n_i), .ce_i(l_ce_i), .mbx_n_i(l_mbx_n_i), .we_n_i(l_we_n_i),
    .oe_n_i(l_oe_n_i), .ub_n_i(l_ub_n_i), .lb_n_i(l_lb_n_i), .bank_i(l_bank_i),
    .own_i(own_q), .sel_i(bank_sel_i), .acc_o(l_acc), .err_o(l_err_o),
    .fire_o(l_fire), .bank_q_o(l_bank_q), .be_q_o(l_be_q)
  );

  bsw_port #(.NBANK(NBANK), .IS_LEFT(1'b0)) u_port_r (
    .clk_i, .rst_ni,
    .ce_n_i(r_ce_n_i), .ce_i(r_ce_i), .mbx_n_i(r_mbx_n_i), .we_n_i(r_we_n_i),
    .oe_n_i(r_oe_n_i), .ub_n_i(r_ub_n_i), .lb_n_i(r_lb_n_i), .bank_i(r_bank_i),
    .own_i(own_q), .sel_i(bank_sel_i), .acc_o(r_acc), .err_o(r_err_o),
    .fire_o(r_fire), .bank_q_o(r_bank_q), .be_q_o(r_be_q)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic              we, re;
    logic [1:0]        be;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;

    always_comb begin
      l_hit[b] = (l_acc.wr || l_acc.rd) && (l_bank_i == BA_W'(b));
      r_hit[b] = (r_acc.wr || r_acc.rd) && (r_bank_i == BA_W'(b));
      we    = (l_hit[b] && l_acc.wr) || (r_hit[b] && r_acc.wr);
      re    = (l_hit[b] && l_acc.rd) || (r_hit[b] && r_acc.rd);
      be    = l_hit[b] ? l_acc.be  : r_acc.be;
      addr  = l_hit[b] ? l_addr_i  : r_addr_i;
      wdata = l_hit[b] ? l_wdata_i : r_wdata_i;
    end

    bsw_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk_i, .rst_ni, .we_i(we), .re_i(re), .be_i(be),
      .addr_i(addr), .wdata_i(wdata), .rdata_o(bank_rd[b])
    );

    assert_bank_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(l_hit[b] && r_hit[b]));
  end

  assign l_rdata_o = l_fire ? (bank_rd[l_bank_q] & byte_mask(l_be_q)) : '0;
  assign r_rdata_o = r_fire ? (bank_rd[r_bank_q] & byte_mask(r_be_q)) : '0;

  assert_err_quiet_l_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_err_o |-> (l_rdata_o == '0));
  assert_err_quiet_r_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_err_o |-> (r_rdata_o == '0));
endmodule

// File: tb/bsw_dpram_tb.sv
module bsw_dpram_tb;
  localparam int ADDR_W = 8;
  localparam int NBANK  = 4;
  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int TOP    = DEPTH - 1;

  typedef struct {
    bit ce_n, ce, mbx_n, we_n, oe_n, ub_n, lb_n;
    int bank, addr, data;
  } req_t;

  logic clk = 0, rst_n = 0;
  logic [NBANK-1:0] bsel = '0;
  req_t lq, rq;
  logic [15:0] l_rdata, r_rdata;
  logic l_err, r_err;
  int n_chk = 0, n_bad = 0;
  int mem [NBANK][DEPTH];
  bit [NBANK-1:0] own_m = '0;

  always #5 clk = ~clk;

  bsw_dpram #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bank_sel_i(bsel),
    .l_ce_n_i(lq.ce_n), .l_ce_i(lq.ce), .l_mbx_n_i(lq.mbx_n), .l_we_n_i(lq.we_n),
    .l_oe_n_i(lq.oe_n), .l_ub_n_i(lq.ub_n), .l_lb_n_i(lq.lb_n),
    .l_bank_i(lq.bank[1:0]), .l_addr_i(lq.addr[ADDR_W-1:0]), .l_wdata_i(lq.data[15:0]),
    .l_rdata_o(l_rdata), .l_err_o(l_err),
    .r_ce_n_i(rq.ce_n), .r_ce_i(rq.ce), .r_mbx_n_i(rq.mbx_n), .r_we_n_i(rq.we_n),
    .r_oe_n_i(rq.oe_n), .r_ub_n_i(rq.ub_n), .r_lb_n_i(rq.lb_n),
    .r_bank_i(rq.bank[1:0]), .r_addr_i(rq.addr[ADDR_W-1:0]), .r_wdata_i(rq.data[15:0]),
    .r_rdata_o(r_rdata), .r_err_o(r_err)
  );

  function automatic req_t idle();
    req_t q = '{ce_n: 1, ce: 1, mbx_n: 1, we_n: 1, oe_n: 1, ub_n: 0, lb_n: 0,
                bank: 0, addr: 0, data: 0};
    return q;
  endfunction

  function automatic req_t wr(int b, int a, int d, bit ub_n = 0, bit lb_n = 0);
    req_t q = idle();
    q.ce_n = 0; q.we_n = 0; q.bank = b; q.addr = a; q.data = d;
    q.ub_n = ub_n; q.lb_n = lb_n;
    return q;
  endfunction

  function automatic req_t rd(int b, int a, bit ub_n = 0, bit lb_n = 0);
    req_t q = idle();
    q.ce_n = 0; q.oe_n = 0; q.bank = b; q.addr = a; q.ub_n = ub_n; q.lb_n = lb_n;
    return q;
  endfunction

  function automatic int mask_of(req_t q);
    return (q.ub_n ? 0 : 'hFF00) | (q.lb_n ? 0 : 'h00FF);
  endfunction

  // reference decision for one port
  function automatic void model(req_t q, bit left, logic [NBANK-1:0] sel,
                                output bit do_wr, output int exp_rd, output bit exp_err);
    bit chip = !q.ce_n && q.ce;
    bit msel = chip && q.mbx_n;
    bit mine = (own_m[q.bank] == left);
    bit mov  = (sel[q.bank] != own_m[q.bank]);
    bit gnt  = msel && mine && !mov;
    do_wr   = gnt && !q.we_n;
    exp_rd  = (gnt && q.we_n && !q.oe_n) ? (mem[q.bank][q.addr] & mask_of(q)) : 0;
    exp_err = (chip && !q.mbx_n) || (msel && !mine);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, req_t l, req_t r, logic [NBANK-1:0] sel);
    bit lw, rw, le, re;
    int lr, rr;
    @(negedge clk);
    lq = l; rq = r; bsel = sel;
    model(l, 1'b1, sel, lw, lr, le);
    model(r, 1'b0, sel, rw, rr, re);
    @(posedge clk);
    if (lw) mem[l.bank][l.addr] = (mem[l.bank][l.addr] & ~mask_of(l)) | (l.data & mask_of(l));
    if (rw) mem[r.bank][r.addr] = (mem[r.bank][r.addr] & ~mask_of(r)) | (r.data & mask_of(r));
    own_m = sel;
    #2;
    check(tag, "l_rdata", int'(l_rdata), lr);
    check(tag, "r_rdata", int'(r_rdata), rr);
    check(tag, "l_err", int'(l_err), int'(le));
    check(tag, "r_err", int'(r_err), int'(re));
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    req_t q;
    lq = idle(); rq = idle();
    repeat (3) @(posedge clk);
    #2;
    check("R6 reset", "l_rdata", int'(l_rdata), 0);
    check("R6 reset", "r_err", int'(r_err), 0);
    @(negedge clk); rst_n = 1;

    // R2: banks 0,1 left, 2,3 right; first cycle is a switch
    step("R2", idle(), idle(), 4'b0011);
    // R1 R10: both ports fill their own banks in the same cycle
    for (int i = 0; i < 4; i++) begin
      step("R10", wr(0, i, 'h1000 + i), wr(2, i, 'h2000 + i), 4'b0011);
      step("R10", wr(1, TOP - i, 'h3000 + i), wr(3, TOP - i, 'h4000 + i), 4'b0011);
    end
    for (int i = 0; i < 4; i++) begin
      step("R1", rd(0, i), rd(2, i), 4'b0011);
      step("R1", rd(1, TOP - i), rd(3, TOP - i), 4'b0011);
    end
    // R4: byte-gated writes
    step("R4", wr(0, 0, 'hAABB, 0, 1), wr(2, 0, 'hCCDD, 1, 0), 4'b0011);
    step("R4", wr(0, 1, 'h5566, 1, 1), wr(2, 1, 'h7788, 1, 1), 4'b0011);
    step("R4", rd(0, 0), rd(2, 0), 4'b0011);
    step("R4", rd(0, 1), rd(2, 1), 4'b0011);
    // R5: partial reads and output enable off
    step("R5", rd(0, 2, 0, 1), rd(2, 2, 1, 0), 4'b0011);
    step("R5", rd(0, 3, 1, 1), rd(2, 3), 4'b0011);
    q = rd(1, TOP); q.oe_n = 1;
    step("R5", q, rd(3, TOP), 4'b0011);
    // R6: read data lasts one cycle only
    step("R6", rd(0, 2), idle(), 4'b0011);
    step("R6", idle(), idle(), 4'b0011);
    // R3: deselect combinations
    q = wr(0, 2, 'hDEAD); q.ce_n = 1;
    step("R3", q, idle(), 4'b0011);
    q = wr(0, 2, 'hBEEF); q.ce = 0;
    step("R3", q, idle(), 4'b0011);
    q = rd(0, 2); q.ce = 0;
    step("R3", q, idle(), 4'b0011);
    step("R3", rd(0, 2), idle(), 4'b0011);
    // R7: access to a bank not owned
    step("R7", wr(2, 3, 'h0BAD), wr(1, 3, 'h0BAD), 4'b0011);
    step("R7", rd(3, TOP), rd(0, 0), 4'b0011);
    step("R7", rd(1, TOP - 3), rd(2, 3), 4'b0011);
    // R8: mailbox select together with chip select
    q = wr(0, 3, 'hF00D); q.mbx_n = 0;
    step("R8", q, idle(), 4'b0011);
    q = rd(2, 3); q.mbx_n = 0;
    step("R8", idle(), q, 4'b0011);
    step("R8", rd(0, 3), idle(), 4'b0011);
    // R9: bank 1 moves from left to right while both touch it
    step("R9", wr(1, TOP, 'h9999), wr(1, TOP, 'h8888), 4'b0001);
    step("R9", idle(), rd(1, TOP), 4'b0001);
    step("R9", rd(0, 0), wr(1, TOP, 'h7777), 4'b0001);
    step("R9", idle(), rd(1, TOP), 4'b0001);
    // R2: left takes all banks, right owns none
    step("R2", idle(), idle(), 4'b1111);
    for (int b = 0; b < 4; b++) step("R2", rd(b, 0), rd(b, 0), 4'b1111);
    step("R2", wr(3, 0, 'h1234), idle(), 4'b1111);
    step("R2", rd(3, 0), idle(), 4'b1111);
    finish_up();
  end
endmodule